// File: doc/BRIEF.md
# Byte-Wide Configuration and Status Register Bank

This block is a bank of configuration and status registers. It sits on a shared, byte-wide register bus that has 32 bank slots. Software reaches it with a plain synchronous access: an address, a write enable and a write byte in, and a registered read byte out. The bank responds only when the upper address bits equal its own bank index. For any other address it keeps its read data at zero, so read data from all banks can be ORed onto one return path.

The bank holds three registers:

- **Pass-through register.** A bus write hands the byte to the core together with a single-cycle pulse. A bus read returns a value that the core drives at all times.
- **Split field.** This 16-bit field is kept inside the bank. It occupies two consecutive addresses, with the high byte at the lower address. Either the bus, one byte at a time, or the core, all 16 bits at once under a load strobe, can change it. Its current value is always visible to the core.
- **Status register.** It has no strobe. The bank samples the core's status input on every clock, and the bus can only read it.

The bus is a simple register port with no flow control. Every cycle is an access, and a read result appears one cycle after its address.

Top module: `csr_byte_bank`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `bus_rdata`, `pt_stb`, `pt_wdata` and `fld_val` are all zero.
- R2: The address is split into a bank index in bits [8:4] and a register offset in bits [3:0]. The bank is selected only when bits [8:4] equal the parameter `BANK_ID` (default 9).
- R3: A selected write to offset 0 raises `pt_stb` for exactly the one cycle after the write, with `pt_wdata` equal to the written byte in that cycle.
- R4: A selected read of offset 0 returns the `pt_rval` value presented in the address cycle.
- R5: A selected write to offset 1 replaces bits [15:8] of `fld_val`, and a write to offset 2 replaces bits [7:0]. The other byte keeps its value. The change is visible in the cycle after the write.
- R6: Selected reads of offset 1 and offset 2 return bits [15:8] and [7:0] of the split field, respectively.
- R7: When `fld_load` is high, the whole field takes `fld_ldata` in the next cycle. This holds even if a bus write to offset 1 or 2 occurs in the same cycle.
- R8: A selected read of offset 3 returns `stat_in` as sampled on the previous clock edge. Bus writes to offset 3 change nothing.
- R9: Read data has one cycle of latency. It is zero after any cycle in which the bank is not selected, and after a read of an unused offset (4 to 15).
- R10: Writes to other banks, and writes to unused offsets, change neither the split field nor the pass-through strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 9 | Bank index [8:4] and register offset [3:0] |
| bus_we | input | 1 | Write enable for the current access |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Registered read byte; zero when not selected |
| pt_wdata | output | 8 | Pass-through byte written by the bus; valid while `pt_stb` is high |
| pt_stb | output | 1 | Single-cycle pulse following a pass-through write |
| pt_rval | input | 8 | Core value returned by reads of offset 0 |
| fld_val | output | 16 | Current value of the split field |
| fld_load | input | 1 | Core load strobe for the split field |
| fld_ldata | input | 16 | Value loaded by `fld_load` |
| stat_in | input | 8 | Status value sampled every clock |

## Verification
The bench targets the following corner cases:

- **Byte order of the split field.** A design with the byte order reversed would show the written byte in the wrong half of `fld_val` and return swapped bytes on readback.
- **Load and bus write in the same cycle.** A design that lets the bus win would leave the bus byte in the field in place of the core's load value.
- **Foreign-bank and unused-offset accesses.** These must neither pulse the strobe, nor alter the field, nor return nonzero data. A design with weak bank decoding would pulse the strobe or leak `pt_rval` onto the shared read path.
- **Pulse length.** The pass-through pulse must last exactly one cycle. A stretched pulse would still be high on the second cycle after the write.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;
  localparam int CSR_DW   = 8;
  localparam int OFS_PT   = 0;
  localparam int OFS_FLD  = 1;
  localparam int OFS_STAT = 3;
endpackage

// File: rtl/csr_addr_dec.sv
module csr_addr_dec #(
  parameter int BANK_W  = 5,
  parameter int OFS_W   = 4,
  parameter int BANK_ID = 9
) (
  input  logic [BANK_W+OFS_W-1:0] addr,
  input  logic                    we,
  output logic                    sel,
  output logic                    wr,
  output logic [OFS_W-1:0]        ofs
);
  localparam int ADDR_W = BANK_W + OFS_W;

  // R2: bank index sits above the offset
  assign sel = (addr[ADDR_W-1:OFS_W] == BANK_W'(BANK_ID));
  assign ofs = addr[OFS_W-1:0];
  assign wr  = sel && we;
endmodule

// File: rtl/csr_pt_reg.sv
module csr_pt_reg #(
  parameter int DW    = 8,
  parameter int OFS_W = 4,
  parameter int SLOT  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [OFS_W-1:0] ofs,
  input  logic [DW-1:0]    wdata,
  output logic             stb,
  output logic [DW-1:0]    data
);
  logic hit;
  assign hit = wr && (ofs == OFS_W'(SLOT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb  <= 1'b0;
      data <= '0;
    end else begin
      stb <= hit;
      if (hit) data <= wdata;
    end
  end

  // R3: a write yields the strobe and the byte one cycle later
  a_r3_pulse_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (stb && data == $past(wdata)));
  // R3: the strobe never rises without a preceding write
  a_r3_pulse_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> !stb);
endmodule

// File: rtl/csr_split_field.sv
module csr_split_field #(
  parameter int DW    = 8,
  parameter int OFS_W = 4,
  parameter int FW    = 16,
  parameter int BASE  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [OFS_W-1:0] ofs,
  input  logic [DW-1:0]    wdata,
  input  logic             load,
  input  logic [FW-1:0]    ldata,
  output logic [FW-1:0]    val,
  output logic             rd_match,
  output logic [DW-1:0]    rd_byte
);
  localparam int NB = FW / DW;

  logic [DW-1:0] slot_q   [NB];
  logic [NB-1:0] slot_hit;

  // slot k sits at offset BASE+k; slot 0 carries the most significant byte
  for (genvar k = 0; k < NB; k++) begin : g_slot
    localparam int LO = (NB - 1 - k) * DW;
    assign slot_hit[k] = (ofs == OFS_W'(BASE + k));
    assign val[LO +: DW] = slot_q[k];

    always_ff @(posedge clk) begin
      if (!rst_n)                  slot_q[k] <= '0;
      else if (load)               slot_q[k] <= ldata[LO +: DW];
      else if (wr && slot_hit[k])  slot_q[k] <= wdata;
    end
  end

  always_comb begin
    rd_byte = '0;
    for (int k = 0; k < NB; k++)
      if (slot_hit[k]) rd_byte = slot_q[k];
  end
  assign rd_match = |slot_hit;

  // R7: core load takes the whole field, bus write or not
  a_r7_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (val == $past(ldata)));
  // R10: no load and no matching bus write keeps the field
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(wr && rd_match)) |=> $stable(val));
  // R6: at most one slot claims an offset
  a_r6_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_hit));
endmodule

// File: rtl/csr_status_field.sv
module csr_status_field #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= din;
  end

  // R8: sampled on every edge, no strobe
  a_r8_sampled: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (q == $past(din)));
endmodule

// File: rtl/csr_byte_bank.sv
module csr_byte_bank
  import csr_bank_pkg::*;
#(
  parameter int BANK_W  = 5,
  parameter int OFS_W   = 4,
  parameter int BANK_ID = 9,
  parameter int FLD_W   = 16,
  parameter int STAT_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [BANK_W+OFS_W-1:0] bus_addr,
  input  logic                    bus_we,
  input  logic [CSR_DW-1:0]       bus_wdata,
  output logic [CSR_DW-1:0]       bus_rdata,
  output logic [CSR_DW-1:0]       pt_wdata,
  output logic                    pt_stb,
  input  logic [CSR_DW-1:0]       pt_rval,
  output logic [FLD_W-1:0]        fld_val,
  input  logic                    fld_load,
  input  logic [FLD_W-1:0]        fld_ldata,
  input  logic [STAT_W-1:0]       stat_in
);
  logic             sel, wr;
  logic [OFS_W-1:0] ofs;
  logic             fld_match;
  logic [CSR_DW-1:0] fld_byte;
  logic [STAT_W-1:0] stat_q;
  logic [CSR_DW-1:0] rd_nxt;

  csr_addr_dec #(.BANK_W(BANK_W), .OFS_W(OFS_W), .BANK_ID(BANK_ID)) u_dec (
    .addr(bus_addr), .we(bus_we), .sel(sel), .wr(wr), .ofs(ofs));

  csr_pt_reg #(.DW(CSR_DW), .OFS_W(OFS_W), .SLOT(OFS_PT)) u_pt (
    .clk(clk), .rst_n(rst_n), .wr(wr), .ofs(ofs), .wdata(bus_wdata),
    .stb(pt_stb), .data(pt_wdata));

  csr_split_field #(.DW(CSR_DW), .OFS_W(OFS_W), .FW(FLD_W), .BASE(OFS_FLD)) u_fld (
    .clk(clk), .rst_n(rst_n), .wr(wr), .ofs(ofs), .wdata(bus_wdata),
    .load(fld_load), .ldata(fld_ldata), .val(fld_val),
    .rd_match(fld_match), .rd_byte(fld_byte));

  csr_status_field #(.W(STAT_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .din(stat_in), .q(stat_q));

  always_comb begin
    rd_nxt = '0;
    if (sel) begin
      if (ofs == OFS_W'(OFS_PT))        rd_nxt = pt_rval;
      else if (fld_match)               rd_nxt = fld_byte;
      else if (ofs == OFS_W'(OFS_STAT)) rd_nxt = CSR_DW'(stat_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_nxt;
  end

  // R9: an unselected cycle gives zero read data next cycle
  a_r9_unsel_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (bus_rdata == '0));
  // R4: pass-through read returns the core value one cycle later
  a_r4_pt_read: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && ofs == OFS_W'(OFS_PT)) |=> (bus_rdata == $past(pt_rval)));
endmodule

// File: tb/csr_byte_bank_tb_top.sv
module csr_byte_bank_tb_top;
  localparam int BANK = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [7:0]  pt_wdata;
  logic        pt_stb;
  logic [7:0]  pt_rval = '0;
  logic [15:0] fld_val;
  logic        fld_load = 1'b0;
  logic [15:0] fld_ldata = '0;
  logic [7:0]  stat_in = '0;

  int errors = 0;
  int checks = 0;

  typedef struct { logic [7:0] exp; int req; } rd_item_t;
  rd_item_t sb_q[$];
  logic rd_issue = 1'b0;
  logic mon_pend = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  csr_byte_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pt_wdata(pt_wdata),
    .pt_stb(pt_stb), .pt_rval(pt_rval), .fld_val(fld_val),
    .fld_load(fld_load), .fld_ldata(fld_ldata), .stat_in(stat_in));

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] adr(input int bank, input int ofs);
    return {bank[4:0], ofs[3:0]};
  endfunction

  task automatic bus_wr(input logic [8:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  // driver: pushes the expected byte, the monitor compares one cycle later
  task automatic bus_rd(input logic [8:0] a, input logic [7:0] e, input int req);
    rd_item_t it;
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0; rd_issue = 1'b1;
    it.exp = e; it.req = req;
    sb_q.push_back(it);
    @(negedge clk);
    rd_issue = 1'b0;
  endtask

  always @(posedge clk) mon_pend <= rd_issue;

  always @(negedge clk) begin
    if (mon_pend) begin
      rd_item_t it;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL R9 actual=read without item expected=queued item");
      end else begin
        it = sb_q.pop_front();
        chk(it.req, 32'(bus_rdata), 32'(it.exp));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(1, 32'(bus_rdata), 0);
    chk(1, 32'(pt_stb), 0);
    chk(1, 32'(fld_val), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(1, 32'(pt_wdata), 0);

    // R3: pass-through write pulses once with the byte
    bus_wr(adr(BANK, 0), 8'h5A);
    chk(3, 32'(pt_stb), 1);
    chk(3, 32'(pt_wdata), 32'h5A);
    @(negedge clk);
    chk(3, 32'(pt_stb), 0);

    // R4: pass-through read
    pt_rval = 8'hC3;
    bus_rd(adr(BANK, 0), 8'hC3, 4);
    pt_rval = 8'h3C;
    bus_rd(adr(BANK, 0), 8'h3C, 4);

    // R5: byte order, high byte at offset 1
    bus_wr(adr(BANK, 1), 8'hAB);
    chk(5, 32'(fld_val), 32'hAB00);
    bus_wr(adr(BANK, 2), 8'hCD);
    chk(5, 32'(fld_val), 32'hABCD);
    bus_wr(adr(BANK, 1), 8'h12);
    chk(5, 32'(fld_val), 32'h12CD);

    // R6: readback of both bytes
    bus_rd(adr(BANK, 1), 8'h12, 6);
    bus_rd(adr(BANK, 2), 8'hCD, 6);

    // R7: core load alone, then load against same-cycle bus write
    @(negedge clk);
    fld_load = 1'b1; fld_ldata = 16'h4321;
    @(negedge clk);
    fld_load = 1'b0;
    chk(7, 32'(fld_val), 32'h4321);
    @(negedge clk);
    bus_addr = adr(BANK, 2); bus_we = 1'b1; bus_wdata = 8'hEE;
    fld_load = 1'b1; fld_ldata = 16'h9876;
    @(negedge clk);
    bus_we = 1'b0; fld_load = 1'b0;
    chk(7, 32'(fld_val), 32'h9876);

    // R8: status sampled, bus writes ignored
    stat_in = 8'h77;
    @(negedge clk);
    bus_rd(adr(BANK, 3), 8'h77, 8);
    bus_wr(adr(BANK, 3), 8'h01);
    bus_rd(adr(BANK, 3), 8'h77, 8);
    stat_in = 8'h88;
    @(negedge clk);
    bus_rd(adr(BANK, 3), 8'h88, 8);

    // R2 / R10: other bank writes change nothing
    bus_wr(adr(BANK + 1, 0), 8'hFF);
    chk(10, 32'(pt_stb), 0);
    bus_wr(adr(BANK - 1, 1), 8'h00);
    chk(2, 32'(fld_val), 32'h9876);
    // R10: unused offset write changes nothing
    bus_wr(adr(BANK, 9), 8'h55);
    chk(10, 32'(pt_stb), 0);
    chk(10, 32'(fld_val), 32'h9876);

    // R9: unselected read and unused offset read give zero
    pt_rval = 8'hF0;
    bus_rd(adr(BANK + 2, 0), 8'h00, 9);
    bus_rd(adr(BANK, 7), 8'h00, 9);
    bus_rd(adr(BANK, 15), 8'h00, 9);
    // R2: same offset in own bank does answer
    bus_rd(adr(BANK, 0), 8'hF0, 2);

    repeat (3) @(negedge clk);
    chk(9, 32'(sb_q.size()), 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule